// File: doc/BRIEF.md
# Clock Phase Setting Converter

This block turns a requested clock phase, in degrees, into the coarse-plus-fine delay setting of one of two phase channels: channel 0 shifts the drive clock and channel 1 shifts the sample clock. The phase is cut into whole 90-degree steps (the quadrant) and a leftover angle. The leftover angle becomes a count of fine delay taps, each assumed to be 60 ps long, for the card clock rate given with the request. The result leaves the block as one 32-bit masked register write. The low half carries the field and the upper half carries per-bit write enables.

The block keeps a copy of the last setting written to each channel. A readback request converts that stored setting back into the phase it actually produces at a given clock rate. All divisions share one multi-cycle restoring divider, so every operation spans several tens of cycles. A single-cycle start strobe launches an operation, busy covers it, and a one-cycle done pulse ends it. On that done pulse the write, the error flag and the readback result are valid.

Top module: `phase_conv`

## Requirements
- R1: For a set request the degrees input is first reduced modulo 360. The quadrant is the reduced value divided by 90, and the leftover is the reduced value modulo 90.
- R2: The fine tap count is the rounded-to-nearest quotient of leftover × 10 000 000 divided by (rate div 1000) × 216. This equals leftover × 10^12 / (rate × 360 × 60 ps).
- R3: A tap count above 255 is clamped to 255.
- R4: The fine enable bit is 1 exactly when the tap count written is nonzero.
- R5: In the low half of the write word, bits [2:1] hold the quadrant, bits [10:3] hold the tap count and bit 11 holds the fine enable. Bit 0 and bits [15:12] are zero.
- R6: The upper half of every write word has bits [27:17] set and all other upper bits clear. `wr_chan_o` names the channel written (0 drive, 1 sample), and each channel keeps its own stored setting.
- R7: A readback of channel c at rate f returns (quadrant × 90 + E) mod 360. E is round(tap × 216 × (f div 10000) / 10^6) when the fine enable is set, and 0 otherwise. The result is always below 360.
- R8: A set request with a rate below 1000 Hz raises `err_o` on its done pulse. It makes no write and leaves the stored setting unchanged.
- R9: A readback at rate 0 returns 0.
- R10: A start strobe that arrives while busy is high is ignored.
- R11: After reset, busy, done, error, write enable and readback output are 0, and both stored settings are zero.
- R12: Busy rises in the cycle after an accepted start and stays high up to and including the single-cycle done pulse. The write enable is high only in that done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 1 | 0 = set phase, 1 = read back phase |
| chan_i | input | 1 | Channel: 0 drive, 1 sample |
| deg_i | input | 10 | Requested phase in degrees (0..1023) |
| rate_i | input | 32 | Card clock rate in Hz |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set request rejected for a too-low rate |
| wr_en_o | output | 1 | Register write strobe |
| wr_chan_o | output | 1 | Channel of the write |
| wr_data_o | output | 32 | Masked register write word |
| rd_deg_o | output | 9 | Readback result in degrees |

## Verification
The assertions take for granted that `start_i` is a clean synchronous strobe and that `op_i`, `chan_i`, `deg_i` and `rate_i` are steady when a start is taken. They also assume the readback result is only consulted on or after a done pulse. The bench drives every input on the falling edge, holds it across the accepting rising edge, and reads results only in the done cycle. Rates stay within 32 bits and include zero, a value just under 1000 Hz, and a value near the top of the range, so that the modulo wrap in readback is exercised.

// File: rtl/phase_pkg.sv
package phase_pkg;

    // Assumed fine tap length in picoseconds and derived scale constants
    localparam int TAP_PS       = 60;
    localparam int TAP_FACTOR   = 36 * (TAP_PS / 10);   // 216
    localparam int SET_SCALE    = 10_000_000;
    localparam int RB_SCALE     = 1_000_000;
    localparam int RB_HALF      = RB_SCALE / 2;
    localparam int SET_RATE_DIV = 1000;
    localparam int RB_RATE_DIV  = 10_000;
    localparam int MIN_RATE     = SET_RATE_DIV;
    localparam int TAP_MAX      = 255;
    localparam logic [10:0] WE_BITS = 11'h7FF;

    typedef enum logic {OP_SET = 1'b0, OP_GET = 1'b1} conv_op_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DIV1, ST_DIV2, ST_DIV3, ST_FIN
    } conv_state_t;

    typedef struct packed {
        logic       en;
        logic [7:0] tap;
        logic [1:0] quad;
    } phase_field_t;

    function automatic logic [31:0] enc_word(phase_field_t f);
        return {4'h0, WE_BITS, 1'b0, 4'h0, f, 1'b0};
    endfunction

endpackage

// File: rtl/phase_divider.sv
module phase_divider #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    acc;
    logic [W-1:0]  qr;
    logic [W-1:0]  den;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    shifted;
    logic          fits;

    always_comb begin
        shifted = {acc[W-1:0], qr[W-1]};
        fits    = (shifted >= {1'b0, den});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0; qr <= '0; den <= '0; cnt <= '0; run <= 1'b0; done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                acc <= '0;
                qr  <= num_i;
                den <= den_i;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                acc <= fits ? (shifted - {1'b0, den}) : shifted;
                qr  <= {qr[W-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run    <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = qr;
    assign rem_o = acc[W-1:0];
endmodule

// File: rtl/phase_split.sv
module phase_split #(
    parameter int DEG_W = 10
) (
    input  logic [DEG_W-1:0] deg_i,
    output logic [1:0]       quad_o,
    output logic [6:0]       rem_o
);
    localparam int WRAPS = (2 ** DEG_W) / 360;

    logic [DEG_W-1:0] wrapped;
    logic [DEG_W-1:0] left;

    always_comb begin
        wrapped = deg_i;
        for (int i = 0; i < WRAPS; i++) begin
            if (wrapped >= DEG_W'(360)) wrapped = wrapped - DEG_W'(360);
        end
        if (wrapped >= DEG_W'(270)) begin
            quad_o = 2'd3; left = wrapped - DEG_W'(270);
        end else if (wrapped >= DEG_W'(180)) begin
            quad_o = 2'd2; left = wrapped - DEG_W'(180);
        end else if (wrapped >= DEG_W'(90)) begin
            quad_o = 2'd1; left = wrapped - DEG_W'(90);
        end else begin
            quad_o = 2'd0; left = wrapped;
        end
        rem_o = left[6:0];
    end
endmodule

// File: rtl/phase_conv.sv
module phase_conv
    import phase_pkg::*;
#(
    parameter int RATE_W = 32,
    parameter int DEG_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              op_i,
    input  logic              chan_i,
    input  logic [DEG_W-1:0]  deg_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              wr_en_o,
    output logic              wr_chan_o,
    output logic [31:0]       wr_data_o,
    output logic [8:0]        rd_deg_o
);
    localparam int DIV_W = RATE_W + 8;

    conv_state_t  state;
    conv_op_t     op_q;
    logic         ch_q;
    logic [1:0]   quad_q;
    logic [6:0]   rem_q;
    logic         err_q;
    logic [8:0]   rd_q;
    phase_field_t fld_q;
    phase_field_t shadow [2];
    phase_field_t rb_fld;

    logic [1:0]       sp_quad;
    logic [6:0]       sp_rem;
    logic             div_go;
    logic [DIV_W-1:0] div_a, div_b, div_quo, div_rem;
    logic             div_done;
    logic [DIV_W-1:0] den_now;
    logic [7:0]       tap_sat;
    logic [7:0]       tap_eff;

    phase_split #(.DEG_W(DEG_W)) u_split (
        .deg_i (deg_i),
        .quad_o(sp_quad),
        .rem_o (sp_rem)
    );

    phase_divider #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .go_i  (div_go),
        .num_i (div_a),
        .den_i (div_b),
        .done_o(div_done),
        .quo_o (div_quo),
        .rem_o (div_rem)
    );

    always_comb begin
        rb_fld  = shadow[ch_q];
        tap_eff = rb_fld.en ? rb_fld.tap : 8'd0;
        den_now = div_quo * DIV_W'(TAP_FACTOR);
        tap_sat = (div_quo > DIV_W'(TAP_MAX)) ? 8'(TAP_MAX) : div_quo[7:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_SET;
            ch_q   <= 1'b0;
            quad_q <= '0;
            rem_q  <= '0;
            err_q  <= 1'b0;
            rd_q   <= '0;
            fld_q  <= '0;
            div_go <= 1'b0;
            div_a  <= '0;
            div_b  <= '0;
            for (int i = 0; i < 2; i++) shadow[i] <= '0;
        end else begin
            div_go <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    op_q   <= conv_op_t'(op_i);
                    ch_q   <= chan_i;
                    quad_q <= sp_quad;
                    rem_q  <= sp_rem;
                    err_q  <= 1'b0;
                    if (op_i == OP_SET && rate_i < RATE_W'(MIN_RATE)) begin
                        err_q <= 1'b1;
                        state <= ST_FIN;
                    end else if (op_i == OP_GET && rate_i == '0) begin
                        rd_q  <= '0;
                        state <= ST_FIN;
                    end else begin
                        div_a  <= DIV_W'(rate_i);
                        div_b  <= (op_i == OP_SET) ? DIV_W'(SET_RATE_DIV) : DIV_W'(RB_RATE_DIV);
                        div_go <= 1'b1;
                        state  <= ST_DIV1;
                    end
                end
                ST_DIV1: if (div_done) begin
                    if (op_q == OP_SET) begin
                        div_a <= DIV_W'(rem_q) * DIV_W'(SET_SCALE) + (den_now >> 1);
                        div_b <= den_now;
                    end else begin
                        div_a <= DIV_W'(tap_eff) * DIV_W'(TAP_FACTOR) * div_quo + DIV_W'(RB_HALF);
                        div_b <= DIV_W'(RB_SCALE);
                    end
                    div_go <= 1'b1;
                    state  <= ST_DIV2;
                end
                ST_DIV2: if (div_done) begin
                    if (op_q == OP_SET) begin
                        fld_q        <= '{en: (tap_sat != 8'd0), tap: tap_sat, quad: quad_q};
                        shadow[ch_q] <= '{en: (tap_sat != 8'd0), tap: tap_sat, quad: quad_q};
                        state        <= ST_FIN;
                    end else begin
                        div_a  <= DIV_W'(rb_fld.quad) * DIV_W'(90) + div_quo;
                        div_b  <= DIV_W'(360);
                        div_go <= 1'b1;
                        state  <= ST_DIV3;
                    end
                end
                ST_DIV3: if (div_done) begin
                    rd_q  <= (|div_rem[DIV_W-1:9]) ? 9'd0 : div_rem[8:0];
                    state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o    = (state != ST_IDLE);
    assign done_o    = (state == ST_FIN);
    assign err_o     = err_q;
    assign wr_en_o   = done_o && (op_q == OP_SET) && !err_q;
    assign wr_chan_o = ch_q;
    assign wr_data_o = enc_word(fld_q);
    assign rd_deg_o  = rd_q;
endmodule

// File: rtl/phase_conv_chk.sv
module phase_conv_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic        wr_en_o,
    input logic [31:0] wr_data_o,
    input logic [8:0]  rd_deg_o
);
    AST_EN_MATCHES_TAP: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_data_o[11] == (|wr_data_o[10:3]))); // R4

    AST_WRITE_MASK: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_data_o[31:16] == 16'h0FFE && wr_data_o[15:12] == 4'h0 && !wr_data_o[0])); // R6

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> !wr_en_o); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R12

    AST_WR_ONLY_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (done_o && busy_o)); // R12

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && start_i) |=> busy_o); // R10

    AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_deg_o < 9'd360); // R7
endmodule

bind phase_conv phase_conv_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .wr_en_o  (wr_en_o),
    .wr_data_o(wr_data_o),
    .rd_deg_o (rd_deg_o)
);

// File: tb/phase_conv_bench.sv
`timescale 1ns/1ps
module phase_conv_bench;
    localparam real CLK_P = 8.0;
    localparam int  NV    = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic        chan_i = 1'b0;
    logic [9:0]  deg_i = '0;
    logic [31:0] rate_i = '0;
    logic        busy_o, done_o, err_o, wr_en_o, wr_chan_o;
    logic [31:0] wr_data_o;
    logic [8:0]  rd_deg_o;

    int checks = 0;
    int errors = 0;
    logic [10:0] sh [2];

    // {op, chan, degrees, rate}
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 1'b0, 10'd45,   32'd100000000},
        {1'b1, 1'b0, 10'd0,    32'd100000000},
        {1'b0, 1'b1, 10'd200,  32'd50000000},
        {1'b1, 1'b1, 10'd0,    32'd50000000},
        {1'b0, 1'b0, 10'd90,   32'd100000000},
        {1'b1, 1'b0, 10'd0,    32'd100000000},
        {1'b0, 1'b1, 10'd89,   32'd1000000},
        {1'b1, 1'b1, 10'd0,    32'd1000000},
        {1'b0, 1'b0, 10'd719,  32'd150000000},
        {1'b1, 1'b0, 10'd0,    32'd4000000000},
        {1'b1, 1'b0, 10'd0,    32'd0},
        {1'b0, 1'b1, 10'd30,   32'd999},
        {1'b1, 1'b1, 10'd0,    32'd1000000},
        {1'b0, 1'b0, 10'd1023, 32'd25000000}
    };

    phase_conv u_phase_conv (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .chan_i(chan_i),
        .deg_i(deg_i), .rate_i(rate_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .wr_en_o(wr_en_o), .wr_chan_o(wr_chan_o),
        .wr_data_o(wr_data_o), .rd_deg_o(rd_deg_o)
    );

    always #(CLK_P / 2.0) clk = ~clk;

    function automatic logic [10:0] m_set(int d, longint unsigned rate);
        longint unsigned v, den, t;
        v   = longint'(d) % 360;
        den = (rate / 1000) * 216;
        t   = ((v % 90) * 64'd10000000 + den / 2) / den;
        if (t > 255) t = 255;
        return {(t != 0), t[7:0], v[1:0] == v[1:0] ? 2'(v / 90) : 2'd0};
    endfunction

    function automatic logic [8:0] m_back(logic [10:0] f, longint unsigned rate);
        longint unsigned s;
        if (rate == 0) return 9'd0;
        s = longint'(f[1:0]) * 90;
        if (f[10]) s += (longint'(f[9:2]) * 216 * (rate / 10000) + 500000) / 1000000;
        return 9'(s % 360);
    endfunction

    task automatic chk(string tag, longint unsigned got, longint unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic op, input logic ch, input logic [9:0] d,
                          input logic [31:0] r, output logic ok);
        int n;
        @(negedge clk);
        start_i = 1'b1; op_i = op; chan_i = ch; deg_i = d; rate_i = r;
        @(negedge clk);
        start_i = 1'b0;
        chk("R12 busy after start", busy_o, 1'b1);
        n = 0;
        while (!done_o && n < 1000) begin
            @(negedge clk);
            n++;
        end
        ok = done_o;
        if (!ok) chk("R12 done timeout", 0, 1);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic ok;
        sh[0] = '0; sh[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state at the ports
        chk("R11 busy", busy_o, 0);
        chk("R11 done", done_o, 0);
        chk("R11 err", err_o, 0);
        chk("R11 wr_en", wr_en_o, 0);
        chk("R11 rd", rd_deg_o, 0);
        run_op(1'b1, 1'b1, 10'd0, 32'd100000000, ok);
        chk("R11 stored sample setting zero", rd_deg_o, 0);

        for (int i = 0; i < NV; i++) begin
            logic        vop, vch;
            logic [9:0]  vd;
            logic [31:0] vr;
            logic [10:0] ef;
            {vop, vch, vd, vr} = VEC[i];
            run_op(vop, vch, vd, vr, ok);
            if (ok) begin
                if (vop == 1'b0) begin
                    if (vr < 1000) begin
                        chk("R8 err on low rate", err_o, 1);
                        chk("R8 no write", wr_en_o, 0);
                    end else begin
                        ef = m_set(int'(vd), longint'(vr));
                        chk("R8 no err", err_o, 0);
                        chk("R6 write strobe", wr_en_o, 1);
                        chk("R6 write channel", wr_chan_o, vch);
                        // R1 R2 R3 R4 R5 R6: full word compared
                        chk("R2 word", wr_data_o, {4'h0, 11'h7FF, 1'b0, 4'h0, ef, 1'b0});
                        sh[vch] = ef;
                    end
                end else begin
                    chk(vr == 0 ? "R9 zero rate readback" : "R7 readback",
                        rd_deg_o, m_back(sh[vch], longint'(vr)));
                    chk("R12 no write on readback", wr_en_o, 0);
                end
                @(negedge clk);
                chk("R12 done single cycle", done_o, 0);
                chk("R12 idle after done", busy_o, 0);
            end
        end

        // R10: start pulses during busy are ignored
        @(negedge clk);
        start_i = 1'b1; op_i = 1'b0; chan_i = 1'b0; deg_i = 10'd10; rate_i = 32'd100000000;
        @(negedge clk);
        chan_i = 1'b1; deg_i = 10'd300;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        begin
            int n;
            n = 0;
            while (!done_o && n < 1000) begin @(negedge clk); n++; end
        end
        chk("R10 write channel kept", wr_chan_o, 0);
        sh[0] = m_set(10, 100000000);
        chk("R10 word kept", wr_data_o, {4'h0, 11'h7FF, 1'b0, 4'h0, sh[0], 1'b0});
        run_op(1'b1, 1'b1, 10'd0, 32'd1000000, ok);
        chk("R10 sample channel untouched", rd_deg_o, m_back(sh[1], 1000000));

        summary();
    end
endmodule